// File: doc/BRIEF.md
# Upper Memory Shadow Segment Decoder

This block decodes every CPU memory access against the upper-memory window from 0xC0000 to 0xFFFFF. That window is split into eight 32 KB segments. For each segment the block decides whether reads and writes are served by on-board DRAM or passed to the external bus. When an access does go external, it also decides whether the ROM chip-select should be driven for an access of any width, or whether the access stays a plain external cycle.

A single shadow-control byte supplies three things: a per-segment enable for the lower six segments, a read-from-DRAM attribute and a write-protect attribute. Segments 6 and 7 (0xF0000–0xFFFFF) are always under shadow control. ROM chip-select coverage is built from three separate enable bits and a fixed pair of top segments. The block also reports whether BIOS space (0xE0000 and above) is being read from shadow DRAM and whether it is still writable in DRAM.

The address is given as a 32 KB granule number, so the byte offset never enters the block. All outputs are registered, one clock after the inputs.

Top module: `shadow_seg_decoder`

## Requirements
- R1: A granule address whose bits [8:3] equal 0x03 (byte address 0xC0000–0xFFFFF) raises hit_o, and seg_o equals granule bits [2:0]. Any other address clears hit_o, sets rd_int_o and wr_int_o, and clears ext_any_o and ext_plain_o.
- R2: Segments 6 and 7 are always shadow-controlled. Segment i (0..5) is shadow-controlled exactly when shadow_cfg_i[i] is 1.
- R3: In a segment that is not shadow-controlled, rd_int_o and wr_int_o are both 0, whatever shadow_cfg_i[7:6] hold.
- R4: In a shadow-controlled segment, rd_int_o equals shadow_cfg_i[7].
- R5: In a shadow-controlled segment, wr_int_o equals the inverse of shadow_cfg_i[6], so a 1 in bit 6 write-protects the DRAM copy.
- R6: Segments 6 and 7 are always in the ROM chip-select set. rom_seg0_i adds segment 0, rom_seg1_i adds segment 1 and rom_seg45_i adds segments 4 and 5. Segments 2 and 3 are never in the set.
- R7: An access goes external when rd_i is 1 with a read routed out, or when wr_i is 1 with a write routed out. Such an access raises ext_any_o if its segment is in the chip-select set and ext_plain_o if it is not. Neither output is raised when there is no strobe or when every strobed direction is internal.
- R8: bios_rd_shadow_o is 1 when a segment at or above 0xE0000 (segments 4–7) is shadow-controlled and shadow_cfg_i[7] is 1. bios_wr_open_o is 1 when such a segment is shadow-controlled and shadow_cfg_i[6] is 0.
- R9: Each output reflects the inputs sampled at the previous rising clock edge. While rst is high the outputs hold the pass-through state: hit_o, seg_o, ext_any_o, ext_plain_o and both BIOS flags are 0, and rd_int_o and wr_int_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shadow_cfg_i | input | 8 | Bits 5:0 segment shadow enables, bit 6 write-protect, bit 7 read-from-DRAM |
| rom_seg0_i | input | 1 | Adds segment 0 to the ROM chip-select set |
| rom_seg1_i | input | 1 | Adds segment 1 to the ROM chip-select set |
| rom_seg45_i | input | 1 | Adds segments 4 and 5 to the ROM chip-select set |
| gran_addr_i | input | 9 | Access address divided by 32 KB (byte address bits 23:15) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| hit_o | output | 1 | Access falls inside the upper-memory window |
| seg_o | output | 3 | Segment index of the access |
| rd_int_o | output | 1 | Reads are served by DRAM |
| wr_int_o | output | 1 | Writes are served by DRAM |
| ext_any_o | output | 1 | External access with ROM chip-select, any width |
| ext_plain_o | output | 1 | External access without ROM chip-select |
| bios_rd_shadow_o | output | 1 | BIOS space is read from shadow DRAM |
| bios_wr_open_o | output | 1 | BIOS space is writable in DRAM |

## Verification
The bench sweeps every value of the shadow byte against all eight combinations of the chip-select bits and all eight segments. It targets segments 6 and 7, which must stay shadow-controlled with their enable bits at 0. A decoder that indexed the enable byte there would send BIOS reads external. Segments 2 and 3 must never draw chip-select, and an index slip in the mask build would turn their external cycles into any-width ROM cycles. The bench also probes granules just below 0xC0000 and just above 0xFFFFF, where a decoder that compared too few address bits would claim the access. It issues strobe-free cycles and single-direction strobes into segments where the other direction is internal, which catches any external marking that ignores the strobes.

// File: rtl/shseg_pkg.sv
package shseg_pkg;
  // field positions inside the shadow-control byte
  localparam int SH_WP_BIT  = 6;  // 1: writes leave DRAM
  localparam int SH_RD_BIT  = 7;  // 1: reads come from DRAM

  // segment roles
  localparam int SEG_ALWAYS_CTRL = 6;  // from here up, always shadow-controlled
  localparam int SEG_ALWAYS_CS   = 6;  // from here up, always in chip-select set
  localparam int SEG_BIOS_FROM   = 4;  // 0xE0000 and above
  localparam int SEG_CS_LO       = 0;
  localparam int SEG_CS_ONE      = 1;
  localparam int SEG_CS_PAIR_A   = 4;
  localparam int SEG_CS_PAIR_B   = 5;

  typedef struct packed {
    logic rd_int;
    logic wr_int;
    logic cs;
  } seg_route_t;
endpackage

// File: rtl/shseg_cs_mask.sv
module shseg_cs_mask
  import shseg_pkg::*;
#(
  parameter int NUM_SEG = 8
) (
  input  logic               rom_seg0_i,
  input  logic               rom_seg1_i,
  input  logic               rom_seg45_i,
  output logic [NUM_SEG-1:0] cs_mask_o
);
  always_comb begin
    for (int i = 0; i < NUM_SEG; i++) begin
      cs_mask_o[i] = (i >= SEG_ALWAYS_CS);
    end
    cs_mask_o[SEG_CS_LO]     = cs_mask_o[SEG_CS_LO]     | rom_seg0_i;
    cs_mask_o[SEG_CS_ONE]    = cs_mask_o[SEG_CS_ONE]    | rom_seg1_i;
    cs_mask_o[SEG_CS_PAIR_A] = cs_mask_o[SEG_CS_PAIR_A] | rom_seg45_i;
    cs_mask_o[SEG_CS_PAIR_B] = cs_mask_o[SEG_CS_PAIR_B] | rom_seg45_i;
  end
endmodule

// File: rtl/shseg_attr.sv
module shseg_attr
  import shseg_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int CFG_W   = 8
) (
  input  logic [CFG_W-1:0]   shadow_cfg_i,
  input  logic [NUM_SEG-1:0] cs_mask_i,
  output seg_route_t         route_o [NUM_SEG],
  output logic               bios_rd_o,
  output logic               bios_wr_o
);
  logic [NUM_SEG-1:0] ctrl;
  logic [NUM_SEG-1:0] bios_seg;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    if (g >= SEG_ALWAYS_CTRL) begin : g_fixed
      assign ctrl[g] = 1'b1;
    end else begin : g_cfg
      assign ctrl[g] = shadow_cfg_i[g];
    end
    assign bios_seg[g]       = (g >= SEG_BIOS_FROM);
    assign route_o[g].rd_int = ctrl[g] & shadow_cfg_i[SH_RD_BIT];
    assign route_o[g].wr_int = ctrl[g] & ~shadow_cfg_i[SH_WP_BIT];
    assign route_o[g].cs     = cs_mask_i[g];
  end

  assign bios_rd_o = (|(ctrl & bios_seg)) & shadow_cfg_i[SH_RD_BIT];
  assign bios_wr_o = (|(ctrl & bios_seg)) & ~shadow_cfg_i[SH_WP_BIT];
endmodule

// File: rtl/shseg_route.sv
module shseg_route
  import shseg_pkg::*;
#(
  parameter int          NUM_SEG     = 8,
  parameter int          GRAN_W      = 9,
  parameter int unsigned REGION_GRAN = 24  // first granule of the window
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [GRAN_W-1:0]          gran_addr_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  seg_route_t                 route_i [NUM_SEG],
  input  logic                       bios_rd_i,
  input  logic                       bios_wr_i,
  output logic                       hit_o,
  output logic [$clog2(NUM_SEG)-1:0] seg_o,
  output logic                       rd_int_o,
  output logic                       wr_int_o,
  output logic                       ext_any_o,
  output logic                       ext_plain_o,
  output logic                       bios_rd_shadow_o,
  output logic                       bios_wr_open_o
);
  localparam int SEG_W = $clog2(NUM_SEG);
  localparam int TAG_W = GRAN_W - SEG_W;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(REGION_GRAN >> SEG_W);

  logic             in_win;
  logic [SEG_W-1:0] seg;
  seg_route_t       sel;
  logic             go_ext;

  assign in_win = (gran_addr_i[GRAN_W-1:SEG_W] == TAG);
  assign seg    = gran_addr_i[SEG_W-1:0];
  assign sel    = route_i[seg];
  assign go_ext = in_win & ((rd_i & ~sel.rd_int) | (wr_i & ~sel.wr_int));

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o            <= 1'b0;
      seg_o            <= '0;
      rd_int_o         <= 1'b1;
      wr_int_o         <= 1'b1;
      ext_any_o        <= 1'b0;
      ext_plain_o      <= 1'b0;
      bios_rd_shadow_o <= 1'b0;
      bios_wr_open_o   <= 1'b0;
    end else begin
      hit_o            <= in_win;
      seg_o            <= in_win ? seg : '0;
      rd_int_o         <= in_win ? sel.rd_int : 1'b1;
      wr_int_o         <= in_win ? sel.wr_int : 1'b1;
      ext_any_o        <= go_ext & sel.cs;
      ext_plain_o      <= go_ext & ~sel.cs;
      bios_rd_shadow_o <= bios_rd_i;
      bios_wr_open_o   <= bios_wr_i;
    end
  end
endmodule

// File: rtl/shadow_seg_decoder.sv
module shadow_seg_decoder
  import shseg_pkg::*;
#(
  parameter int          NUM_SEG     = 8,
  parameter int          CFG_W       = 8,
  parameter int          GRAN_W      = 9,
  parameter int unsigned REGION_GRAN = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CFG_W-1:0]           shadow_cfg_i,
  input  logic                       rom_seg0_i,
  input  logic                       rom_seg1_i,
  input  logic                       rom_seg45_i,
  input  logic [GRAN_W-1:0]          gran_addr_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  output logic                       hit_o,
  output logic [$clog2(NUM_SEG)-1:0] seg_o,
  output logic                       rd_int_o,
  output logic                       wr_int_o,
  output logic                       ext_any_o,
  output logic                       ext_plain_o,
  output logic                       bios_rd_shadow_o,
  output logic                       bios_wr_open_o
);
  logic [NUM_SEG-1:0] cs_mask;
  seg_route_t         route [NUM_SEG];
  logic               bios_rd;
  logic               bios_wr;

  shseg_cs_mask #(.NUM_SEG(NUM_SEG)) u_mask (
    .rom_seg0_i (rom_seg0_i),
    .rom_seg1_i (rom_seg1_i),
    .rom_seg45_i(rom_seg45_i),
    .cs_mask_o  (cs_mask)
  );

  shseg_attr #(.NUM_SEG(NUM_SEG), .CFG_W(CFG_W)) u_attr (
    .shadow_cfg_i(shadow_cfg_i),
    .cs_mask_i   (cs_mask),
    .route_o     (route),
    .bios_rd_o   (bios_rd),
    .bios_wr_o   (bios_wr)
  );

  shseg_route #(.NUM_SEG(NUM_SEG), .GRAN_W(GRAN_W), .REGION_GRAN(REGION_GRAN)) u_route (
    .clk             (clk),
    .rst             (rst),
    .gran_addr_i     (gran_addr_i),
    .rd_i            (rd_i),
    .wr_i            (wr_i),
    .route_i         (route),
    .bios_rd_i       (bios_rd),
    .bios_wr_i       (bios_wr),
    .hit_o           (hit_o),
    .seg_o           (seg_o),
    .rd_int_o        (rd_int_o),
    .wr_int_o        (wr_int_o),
    .ext_any_o       (ext_any_o),
    .ext_plain_o     (ext_plain_o),
    .bios_rd_shadow_o(bios_rd_shadow_o),
    .bios_wr_open_o  (bios_wr_open_o)
  );
endmodule

// File: rtl/shseg_checker.sv
module shseg_checker #(
  parameter int NUM_SEG = 8,
  parameter int CFG_W   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [CFG_W-1:0]           shadow_cfg_i,
  input logic                       hit_o,
  input logic [$clog2(NUM_SEG)-1:0] seg_o,
  input logic                       rd_int_o,
  input logic                       wr_int_o,
  input logic                       ext_any_o,
  input logic                       ext_plain_o,
  input logic                       bios_rd_shadow_o,
  input logic                       bios_wr_open_o
);
  logic             armed;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cfg_q <= '0;
    end else begin
      armed <= 1'b1;
      cfg_q <= shadow_cfg_i;
    end
  end

  p_pass_through_r1: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (rd_int_o && wr_int_o && !ext_any_o && !ext_plain_o));

  p_ext_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(ext_any_o && ext_plain_o));

  p_top_cs_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_o && int'(seg_o) >= 6 && (ext_any_o || ext_plain_o)) |-> ext_any_o);

  p_low_no_cs_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_o && (int'(seg_o) == 2 || int'(seg_o) == 3)) |-> !ext_any_o);

  p_unshadowed_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && hit_o && int'(seg_o) < 6 && !cfg_q[seg_o]) |-> (!rd_int_o && !wr_int_o));

  p_top_read_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && hit_o && int'(seg_o) >= 6) |-> (rd_int_o == cfg_q[7]));

  p_top_write_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && hit_o && int'(seg_o) >= 6) |-> (wr_int_o == !cfg_q[6]));

  p_bios_flags_r8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (bios_rd_shadow_o == $past(shadow_cfg_i[7]) &&
               bios_wr_open_o == !$past(shadow_cfg_i[6])));
endmodule

bind shadow_seg_decoder shseg_checker #(.NUM_SEG(NUM_SEG), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/shadow_seg_decoder_bench.sv
module shadow_seg_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] shadow_cfg_i = '0;
  logic       rom_seg0_i = 1'b0, rom_seg1_i = 1'b0, rom_seg45_i = 1'b0;
  logic [8:0] gran_addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic       hit_o, rd_int_o, wr_int_o, ext_any_o, ext_plain_o;
  logic       bios_rd_shadow_o, bios_wr_open_o;
  logic [2:0] seg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_seg_decoder u_shadow_seg_decoder (
    .clk(clk), .rst(rst), .shadow_cfg_i(shadow_cfg_i),
    .rom_seg0_i(rom_seg0_i), .rom_seg1_i(rom_seg1_i), .rom_seg45_i(rom_seg45_i),
    .gran_addr_i(gran_addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .hit_o(hit_o), .seg_o(seg_o), .rd_int_o(rd_int_o), .wr_int_o(wr_int_o),
    .ext_any_o(ext_any_o), .ext_plain_o(ext_plain_o),
    .bios_rd_shadow_o(bios_rd_shadow_o), .bios_wr_open_o(bios_wr_open_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cfg=%02h cs=%0d%0d%0d gran=%03h rd=%0d wr=%0d)",
               tag, act, exp, shadow_cfg_i, rom_seg0_i, rom_seg1_i, rom_seg45_i,
               gran_addr_i, rd_i, wr_i);
    end
  endtask

  // drive at a falling edge, the result is registered at the next rising edge,
  // sample at the falling edge after that
  task automatic access(input logic [8:0] g, input logic r, input logic w);
    gran_addr_i = g; rd_i = r; wr_i = w;
    @(negedge clk);
  endtask

  task automatic expect_window(input int seg, input logic r, input logic w);
    bit ctrl, rdi, wri, cs, ext;
    ctrl = (seg >= 6) || shadow_cfg_i[seg];
    rdi  = ctrl && shadow_cfg_i[7];
    wri  = ctrl && !shadow_cfg_i[6];
    cs   = (seg >= 6) || (seg == 0 && rom_seg0_i) || (seg == 1 && rom_seg1_i) ||
           ((seg == 4 || seg == 5) && rom_seg45_i);
    ext  = (r && !rdi) || (w && !wri);
    chk("R1 hit", int'(hit_o), 1);
    chk("R1 seg", int'(seg_o), seg);
    if (!ctrl) begin
      chk("R3 rd_int", int'(rd_int_o), 0);
      chk("R3 wr_int", int'(wr_int_o), 0);
    end else begin
      chk(seg >= 6 ? "R2 R4 rd_int" : "R4 rd_int", int'(rd_int_o), int'(rdi));
      chk(seg >= 6 ? "R2 R5 wr_int" : "R5 wr_int", int'(wr_int_o), int'(wri));
    end
    chk("R6 R7 ext_any", int'(ext_any_o), int'(ext && cs));
    chk("R7 ext_plain", int'(ext_plain_o), int'(ext && !cs));
    chk("R8 bios_rd", int'(bios_rd_shadow_o), int'(shadow_cfg_i[7]));
    chk("R8 bios_wr", int'(bios_wr_open_o), int'(!shadow_cfg_i[6]));
  endtask

  task automatic expect_outside(input string where);
    chk({"R1 hit ", where}, int'(hit_o), 0);
    chk({"R1 rd_int ", where}, int'(rd_int_o), 1);
    chk({"R1 wr_int ", where}, int'(wr_int_o), 1);
    chk({"R1 ext_any ", where}, int'(ext_any_o), 0);
    chk({"R1 ext_plain ", where}, int'(ext_plain_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    gran_addr_i = 9'h1F8; rd_i = 1'b1; wr_i = 1'b1; shadow_cfg_i = 8'hFF;
    repeat (3) @(negedge clk);
    // R9: reset holds the pass-through state
    chk("R9 reset hit", int'(hit_o), 0);
    chk("R9 reset seg", int'(seg_o), 0);
    chk("R9 reset rd_int", int'(rd_int_o), 1);
    chk("R9 reset wr_int", int'(wr_int_o), 1);
    chk("R9 reset ext_any", int'(ext_any_o), 0);
    chk("R9 reset ext_plain", int'(ext_plain_o), 0);
    chk("R9 reset bios_rd", int'(bios_rd_shadow_o), 0);
    chk("R9 reset bios_wr", int'(bios_wr_open_o), 0);
    rst = 1'b0;

    // R9: one-cycle latency, output tracks the previous edge only
    shadow_cfg_i = 8'h00;
    access(9'h018, 1'b1, 1'b0);
    chk("R9 latency ext_plain", int'(ext_plain_o), 1);
    gran_addr_i = 9'h000;
    @(posedge clk); #1;
    chk("R9 latency same cycle hit", int'(hit_o), 0);
    @(negedge clk);

    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int csv = 0; csv < 8; csv++) begin
        shadow_cfg_i = 8'(cfg);
        rom_seg0_i = csv[0]; rom_seg1_i = csv[1]; rom_seg45_i = csv[2];
        for (int s = 0; s < 8; s++) begin
          logic r, w;
          int pat;
          pat = (s + cfg + csv) % 4;
          r = pat[0]; w = pat[1];
          access(9'(24 + s), r, w);
          expect_window(s, r, w);
        end
      end
      if (cfg % 32 == 0) begin
        // R1 boundaries: just below 0xC0000, just above 0xFFFFF, and an aliasing granule
        access(9'h017, 1'b1, 1'b1); expect_outside("below window");
        access(9'h020, 1'b1, 1'b1); expect_outside("above window");
        access(9'h118, 1'b1, 1'b1); expect_outside("alias above 1MB");
        access(9'h000, 1'b0, 1'b1); expect_outside("low memory");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule